// File: doc/BRIEF.md
# SMRAM and TSEG Access Router

This block decides where each CPU memory request goes when system-management RAM is in play. A small byte-wide configuration port programs two control registers. The first holds the global SMM enable, the open bit and the lock bit. The second holds the high-alias enable, the TSEG enable and the TSEG size code. From these registers, the request address and the request's SMM-mode flag, the block produces a route code on every cycle. The code sends the request to DRAM, to the PCI/legacy-video path, or to a blackhole.

Four address ranges are involved:
- the 128 KB legacy window at 0xA0000–0xBFFFF;
- its high alias at 0xFEDA0000–0xFEDBFFFF;
- a TSEG carve-out at the top of low memory;
- everything else, which goes to DRAM below the top of low memory and to PCI above it.

The top of low memory comes from a static input in 1 MB units. Blackhole reads return all-ones data for the requested bytes, and blackhole writes are dropped. Once the lock bit is set, the configuration is frozen until reset.

Top module: `smram_tseg_router`

## Requirements
- R1: After reset both control registers read 0x00 (control byte: bit0 global enable, bit1 open, bit2 lock; extended byte: bit0 high enable, bits 2:1 TSEG size, bit3 TSEG enable), and a non-SMM access to 0xA0000 routes to PCI (route code 1; code 0 is DRAM, code 2 is blackhole).
- R2: While unlocked, a write with cfg_sel=0 updates only control bits 2:0, and a write with cfg_sel=1 updates only extended bits 3:0. All other bits read back as zero.
- R3: If a write leaves the lock bit set, the open bit reads 0. While locked, writes to either register change nothing until reset.
- R4: With open set, a non-SMM access to the legacy window goes to DRAM when high enable is 0, and a non-SMM access to the high alias goes to DRAM when high enable is 1. Each of these goes to PCI otherwise.
- R5: With open clear, non-SMM accesses to both the legacy window and the high alias go to PCI.
- R6: With global enable set, an SMM access reaches DRAM in the legacy window when high enable is 0, and in the high alias when high enable is 1. With global enable and open both clear, SMM accesses to both ranges go to PCI.
- R7: With TSEG enabled, size codes 0, 1 and 2 select 1, 2 and 8 MB. Code 3, or TSEG disabled, gives no TSEG.
- R8: TSEG spans [top − size, top), where top is low_mem_mb × 1 MB. Inside it, non-SMM accesses route to the blackhole and SMM accesses route to DRAM.
- R9: A blackhole read of 1, 2, 3 or 4 bytes returns 0xFF in each requested byte lane and zero above. A blackhole write, and any non-blackhole access, returns zero data and leaves both registers unchanged.
- R10: Addresses outside the three special ranges route to DRAM below top and to PCI at or above top.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_sel | input | 1 | 0 selects the control byte, 1 selects the extended byte |
| cfg_wdata | input | 8 | Configuration write data |
| low_mem_mb | input | AW-20 | Top of low memory in 1 MB units (static) |
| req_addr | input | AW | Request byte address |
| req_smm | input | 1 | Request issued in SMM mode |
| req_write | input | 1 | Request is a write |
| req_bytes | input | 3 | Request size in bytes (1 to 4) |
| smram_ctl_o | output | 8 | Current control byte |
| ext_ctl_o | output | 8 | Current extended byte |
| route_o | output | 2 | Route code: 0 DRAM, 1 PCI, 2 blackhole |
| rsp_rdata | output | 32 | Blackhole read data |

## Verification
The assertions assume that low_mem_mb stays constant while reset is released. They also assume that low_mem_mb lies above the legacy window and below the high alias, so the three special ranges never overlap. The bench keeps low_mem_mb fixed at 512 for the whole run. It changes the configuration only through the byte port, and it drives req_bytes between 1 and 4 whenever a blackhole read is expected to return data.

// File: rtl/smram_tseg_router.sv
module smram_tseg_router #(
  parameter int AW = 32,
  parameter int MBW = AW - 20,
  parameter logic [7:0] CTL_DEF = 8'h00,
  parameter logic [7:0] EXT_DEF = 8'h00,
  parameter logic [7:0] CTL_WM = 8'h07,
  parameter logic [7:0] EXT_WM = 8'h0F,
  parameter logic [7:0] CTL_WM_LK = 8'h00,
  parameter logic [7:0] EXT_WM_LK = 8'h00
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic           cfg_sel,
  input  logic [7:0]     cfg_wdata,
  input  logic [MBW-1:0] low_mem_mb,
  input  logic [AW-1:0]  req_addr,
  input  logic           req_smm,
  input  logic           req_write,
  input  logic [2:0]     req_bytes,
  output logic [7:0]     smram_ctl_o,
  output logic [7:0]     ext_ctl_o,
  output logic [1:0]     route_o,
  output logic [31:0]    rsp_rdata
);
  localparam logic [1:0] RT_DRAM = 2'd0;
  localparam logic [1:0] RT_PCI  = 2'd1;
  localparam logic [1:0] RT_BH   = 2'd2;
  localparam logic [AW-1:0] LOW_BASE = AW'(32'h000A_0000);
  localparam logic [AW-1:0] HI_BASE  = AW'(32'hFEDA_0000);

  logic [7:0] ctl_q, ext_q, ctl_nx, ext_nx;
  wire locked = ctl_q[2];
  wire [7:0] ctl_wm = locked ? CTL_WM_LK : CTL_WM;
  wire [7:0] ext_wm = locked ? EXT_WM_LK : EXT_WM;

  always_comb begin
    ctl_nx = ctl_q;
    ext_nx = ext_q;
    if (cfg_we && !cfg_sel) ctl_nx = (ctl_q & ~ctl_wm) | (cfg_wdata & ctl_wm);
    if (cfg_we && cfg_sel)  ext_nx = (ext_q & ~ext_wm) | (cfg_wdata & ext_wm);
    if (ctl_nx[2]) ctl_nx[1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= CTL_DEF;
      ext_q <= EXT_DEF;
    end else begin
      ctl_q <= ctl_nx;
      ext_q <= ext_nx;
    end
  end

  assign smram_ctl_o = ctl_q;
  assign ext_ctl_o   = ext_q;

  wire g_en   = ctl_q[0];
  wire open_b = ctl_q[1];
  wire hi_en  = ext_q[0];

  logic [3:0] tseg_mb;
  always_comb begin
    case (ext_q[2:1])
      2'd0:    tseg_mb = 4'd1;
      2'd1:    tseg_mb = 4'd2;
      2'd2:    tseg_mb = 4'd8;
      default: tseg_mb = 4'd0;
    endcase
    if (!ext_q[3]) tseg_mb = 4'd0;
  end

  wire [AW-1:0] top       = {low_mem_mb, 20'b0};
  wire [AW-1:0] tseg_base = top - {{(AW-24){1'b0}}, tseg_mb, 20'b0};

  wire in_low  = req_addr[AW-1:17] == LOW_BASE[AW-1:17];
  wire in_hi   = req_addr[AW-1:17] == HI_BASE[AW-1:17];
  wire in_tseg = (tseg_mb != 4'd0) && (req_addr >= tseg_base) && (req_addr < top);
  wire smram_vis = open_b || (req_smm && g_en);

  always_comb begin
    if (in_hi)        route_o = (hi_en && smram_vis) ? RT_DRAM : RT_PCI;
    else if (in_low)  route_o = (!hi_en && smram_vis) ? RT_DRAM : RT_PCI;
    else if (in_tseg) route_o = req_smm ? RT_DRAM : RT_BH;
    else              route_o = (req_addr < top) ? RT_DRAM : RT_PCI;
  end

  always_comb begin
    rsp_rdata = 32'h0;
    if (route_o == RT_BH && !req_write) begin
      case (req_bytes)
        3'd1:    rsp_rdata = 32'h0000_00FF;
        3'd2:    rsp_rdata = 32'h0000_FFFF;
        3'd3:    rsp_rdata = 32'h00FF_FFFF;
        3'd4:    rsp_rdata = 32'hFFFF_FFFF;
        default: rsp_rdata = 32'h0;
      endcase
    end
  end
endmodule

module smram_tseg_router_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] req_addr,
  input logic          req_smm,
  input logic          req_write,
  input logic [2:0]    req_bytes,
  input logic [7:0]    smram_ctl_o,
  input logic [7:0]    ext_ctl_o,
  input logic [1:0]    route_o,
  input logic [31:0]   rsp_rdata
);
  wire low_win = req_addr[AW-1:17] == 15'h0005;
  wire hi_win  = req_addr[AW-1:17] == 15'h7F6D;

  a_r3_lock_clears_open: assert property (@(posedge clk) disable iff (!rst_n)
    smram_ctl_o[2] |-> !smram_ctl_o[1]);
  a_r3_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    smram_ctl_o[2] |=> ($stable(smram_ctl_o) && $stable(ext_ctl_o)));
  a_r8_blackhole_nonsmm_only: assert property (@(posedge clk) disable iff (!rst_n)
    (route_o == 2'd2) |-> !req_smm);
  a_r5_closed_nonsmm_pci: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_smm && !smram_ctl_o[1] && (low_win || hi_win)) |-> (route_o == 2'd1));
  a_r9_full_word_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (route_o == 2'd2 && !req_write && req_bytes == 3'd4) |-> (rsp_rdata == 32'hFFFF_FFFF));
  a_r9_no_data_elsewhere: assert property (@(posedge clk) disable iff (!rst_n)
    (route_o != 2'd2 || req_write) |-> (rsp_rdata == 32'h0));
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (smram_ctl_o[7:3] == 5'd0) && (ext_ctl_o[7:4] == 4'd0));
endmodule

bind smram_tseg_router smram_tseg_router_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_smm(req_smm),
  .req_write(req_write), .req_bytes(req_bytes), .smram_ctl_o(smram_ctl_o),
  .ext_ctl_o(ext_ctl_o), .route_o(route_o), .rsp_rdata(rsp_rdata)
);

// File: tb/smram_tseg_router_tb_top.sv
module smram_tseg_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [7:0]  cfg_wdata = 8'h0;
  logic [11:0] low_mem_mb = 12'd512;
  logic [31:0] req_addr = 32'h0;
  logic        req_smm = 1'b0;
  logic        req_write = 1'b0;
  logic [2:0]  req_bytes = 3'd4;
  logic [7:0]  smram_ctl_o, ext_ctl_o;
  logic [1:0]  route_o;
  logic [31:0] rsp_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  smram_tseg_router dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .low_mem_mb(low_mem_mb), .req_addr(req_addr),
    .req_smm(req_smm), .req_write(req_write), .req_bytes(req_bytes),
    .smram_ctl_o(smram_ctl_o), .ext_ctl_o(ext_ctl_o), .route_o(route_o),
    .rsp_rdata(rsp_rdata)
  );

  // {req[3:0], ctl[7:0], ext[7:0], addr[31:0], smm, expected route[1:0]}
  localparam int NV = 21;
  localparam logic [54:0] VEC [NV] = '{
    {4'd5,  8'h00, 8'h00, 32'h000A_0000, 1'b0, 2'd1}, // R5
    {4'd4,  8'h02, 8'h00, 32'h000A_0000, 1'b0, 2'd0}, // R4
    {4'd4,  8'h02, 8'h01, 32'h000A_0000, 1'b0, 2'd1}, // R4
    {4'd4,  8'h02, 8'h01, 32'hFEDA_0000, 1'b0, 2'd0}, // R4
    {4'd5,  8'h00, 8'h01, 32'hFEDA_0010, 1'b0, 2'd1}, // R5
    {4'd6,  8'h01, 8'h00, 32'h000B_FFFF, 1'b1, 2'd0}, // R6
    {4'd6,  8'h01, 8'h01, 32'h000A_0000, 1'b1, 2'd1}, // R6
    {4'd6,  8'h01, 8'h01, 32'hFEDB_FFFF, 1'b1, 2'd0}, // R6
    {4'd6,  8'h00, 8'h00, 32'h000A_0000, 1'b1, 2'd1}, // R6
    {4'd6,  8'h00, 8'h01, 32'hFEDA_0000, 1'b1, 2'd1}, // R6
    {4'd8,  8'h00, 8'h08, 32'h1FF0_0000, 1'b0, 2'd2}, // R8
    {4'd8,  8'h00, 8'h08, 32'h1FEF_FFFF, 1'b0, 2'd0}, // R8
    {4'd8,  8'h00, 8'h08, 32'h1FF0_0000, 1'b1, 2'd0}, // R8
    {4'd7,  8'h00, 8'h0A, 32'h1FE0_0000, 1'b0, 2'd2}, // R7
    {4'd7,  8'h00, 8'h0C, 32'h1F80_0000, 1'b0, 2'd2}, // R7
    {4'd7,  8'h00, 8'h0C, 32'h1F7F_FFFF, 1'b0, 2'd0}, // R7
    {4'd7,  8'h00, 8'h0E, 32'h1FFF_FFFF, 1'b0, 2'd0}, // R7
    {4'd7,  8'h00, 8'h04, 32'h1FFF_FFFF, 1'b0, 2'd0}, // R7
    {4'd10, 8'h00, 8'h08, 32'h2000_0000, 1'b0, 2'd1}, // R10
    {4'd8,  8'h00, 8'h08, 32'h1FFF_FFFF, 1'b0, 2'd2}, // R8
    {4'd10, 8'h00, 8'h00, 32'h000C_0000, 1'b0, 2'd0}  // R10
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic probe(input logic [31:0] a, input logic smm, input logic wr, input logic [2:0] nb);
    req_addr = a; req_smm = smm; req_write = wr; req_bytes = nb;
    #1;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1", {24'h0, smram_ctl_o}, 32'h0);
    check("R1", {24'h0, ext_ctl_o}, 32'h0);
    probe(32'h000A_0000, 1'b0, 1'b0, 3'd4);
    check("R1", {30'h0, route_o}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      cfg_write(1'b0, VEC[i][50:43]);
      cfg_write(1'b1, VEC[i][42:35]);
      probe(VEC[i][34:3], VEC[i][2], 1'b0, 3'd4);
      check($sformatf("R%0d vec %0d", VEC[i][54:51], i), {30'h0, route_o}, {30'h0, VEC[i][1:0]});
    end

    // R9 blackhole read widths and write discard (TSEG 1 MB enabled)
    cfg_write(1'b0, 8'h00);
    cfg_write(1'b1, 8'h08);
    probe(32'h1FF0_0040, 1'b0, 1'b0, 3'd1); check("R9 1B", rsp_rdata, 32'h0000_00FF);
    probe(32'h1FF0_0040, 1'b0, 1'b0, 3'd2); check("R9 2B", rsp_rdata, 32'h0000_FFFF);
    probe(32'h1FF0_0040, 1'b0, 1'b0, 3'd3); check("R9 3B", rsp_rdata, 32'h00FF_FFFF);
    probe(32'h1FF0_0040, 1'b0, 1'b0, 3'd4); check("R9 4B", rsp_rdata, 32'hFFFF_FFFF);
    probe(32'h1FF0_0040, 1'b0, 1'b1, 3'd4); check("R9 wr", rsp_rdata, 32'h0);
    @(negedge clk);
    check("R9 regs", {16'h0, smram_ctl_o, ext_ctl_o}, 32'h0000_0008);
    probe(32'h1FF0_0040, 1'b1, 1'b0, 3'd4); check("R9 smm", rsp_rdata, 32'h0);

    // R2 write masks while unlocked
    cfg_write(1'b0, 8'hF3);
    check("R2 ctl", {24'h0, smram_ctl_o}, 32'h03);
    cfg_write(1'b1, 8'hFF);
    check("R2 ext", {24'h0, ext_ctl_o}, 32'h0F);

    // R3 lock clears open and freezes both registers
    cfg_write(1'b1, 8'h01);
    cfg_write(1'b0, 8'h07);
    check("R3 lock", {24'h0, smram_ctl_o}, 32'h05);
    cfg_write(1'b0, 8'h02);
    check("R3 ctl frozen", {24'h0, smram_ctl_o}, 32'h05);
    cfg_write(1'b1, 8'h08);
    check("R3 ext frozen", {24'h0, ext_ctl_o}, 32'h01);
    probe(32'hFEDA_0000, 1'b0, 1'b0, 3'd4);
    check("R3 closed", {30'h0, route_o}, 32'd1);

    // R1 reset unlocks and restores masks
    do_reset();
    check("R1 after lock", {16'h0, smram_ctl_o, ext_ctl_o}, 32'h0);
    cfg_write(1'b0, 8'h02);
    check("R1 unlocked", {24'h0, smram_ctl_o}, 32'h02);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule